// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block moves a processor subsystem between its run state and two low-power states. In light idle only the CPU clock stops. In deep stop the whole system clock is halted as well. Software first picks the target state in a small standby field. The CPU's wait-for-interrupt strobe then starts the entry. An enabled interrupt or a non-maskable interrupt brings the subsystem back, and reset does so from any state.

Leaving deep stop is not immediate. The sequencer raises a warm-up request towards the oscillator timer and keeps every clock off until the timer reports completion. Leaving idle takes a single cycle.

All configuration registers sit behind a key register. A write to the standby field or to the peripheral clock-enable mask is applied only while the key holds 0xC1; otherwise the write is dropped without notice. The key register itself can always be written.

Top module: `lpm_ctrl`

## Requirements
- R1: A synchronous reset puts the block in the run state: `cpu_clk_en`=1, `sys_clk_en`=1, `warmup_req`=0, `periph_clk_en`=0, the key's low byte is 0xC1, and the standby field is 00.
- R2: The key register (address 0) accepts every write. It stores `wr_data[7:0]`, and a read returns that byte with bits 31:8 as zero.
- R3: Writes to the standby register (address 1, bits 1:0) and the peripheral enable register (address 2, bits PCLK_W-1:0) take effect only while the key holds 0xC1. Otherwise they are discarded. A read returns data one cycle after `rd_addr` is presented.
- R4: A `wfi` strobe in run, with no pending wake, while standby is 00, 10 or 11, enters idle on the next cycle: `cpu_clk_en`=0 and `sys_clk_en`=1.
- R5: `periph_clk_en` keeps its programmed value while the block is in a low-power state.
- R6: A `wfi` strobe in run, with no pending wake, while standby is 01, enters deep stop on the next cycle: `cpu_clk_en`=0 and `sys_clk_en`=0. `cpu_clk_en` is never 1 while `sys_clk_en` is 0.
- R7: `irq` or `nmi` in idle returns the block to run on the next cycle.
- R8: `irq` or `nmi` in deep stop raises `warmup_req` on the next cycle, with both clocks still off. The block holds that condition until `warmup_done` is 1, and returns to run on the following cycle with `warmup_req`=0.
- R9: If `irq` or `nmi` is already 1 in the cycle that `wfi` is strobed, the block stays in run.
- R10: Reset returns the block to run from any state, including deep stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Registered read data |
| wfi | input | 1 | Wait-for-interrupt strobe from the CPU |
| irq | input | 1 | An enabled interrupt is pending |
| nmi | input | 1 | Non-maskable interrupt |
| warmup_done | input | 1 | Oscillator warm-up finished |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_clk_en | output | 1 | System clock enable |
| warmup_req | output | 1 | Request to the oscillator warm-up timer |
| periph_clk_en | output | PCLK_W | Programmed peripheral clock enables |

## Verification
Assertions check the following on every cycle:
- The clock ordering: the CPU clock is never on while the system clock is off.
- The one-cycle exits from idle and from deep stop into warm-up.
- Warm-up is held with clocks off while `warmup_done` is low.
- A pending wake cancels an entry.
- The key register captures every write, and a locked write leaves the standby field unchanged.

Only the bench scenarios can show the rest:
- That the full decode of all four standby codes, observed at the outputs, matches the intended modes.
- That locked writes leave nothing visible on read-back or on the peripheral enables.
- That the peripheral mask survives a low-power episode.
- That reset in the middle of deep stop brings back both clocks.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    LP_RUN  = 2'd0,
    LP_IDLE = 2'd1,
    LP_STOP = 2'd2,
    LP_WARM = 2'd3
  } lp_state_t;

  localparam int          KEY_W    = 8;
  localparam logic [7:0]  KEY_OPEN = 8'hC1;
  localparam logic [1:0]  SB_DEEP  = 2'b01;
  localparam int          SB_W     = 2;

  localparam int ADR_KEY   = 0;
  localparam int ADR_SBY   = 1;
  localparam int ADR_PCLK  = 2;
endpackage

// File: rtl/lpm_regs.sv
module lpm_regs
  import lpm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int PCLK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [SB_W-1:0]   standby,
  output logic [PCLK_W-1:0] periph_en
);
  localparam int KEY_PAD  = DATA_W - KEY_W;
  localparam int SB_PAD   = DATA_W - SB_W;
  localparam int PCLK_PAD = DATA_W - PCLK_W;

  logic [KEY_W-1:0] key_q;
  logic             open_q;
  logic             hit_key, hit_sby, hit_pclk;

  assign open_q   = (key_q == KEY_OPEN);
  assign hit_key  = wr_en && (wr_addr == ADDR_W'(ADR_KEY));
  assign hit_sby  = wr_en && (wr_addr == ADDR_W'(ADR_SBY));
  assign hit_pclk = wr_en && (wr_addr == ADDR_W'(ADR_PCLK));

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q     <= KEY_OPEN;
      standby   <= '0;
      periph_en <= '0;
    end else begin
      if (hit_key)            key_q     <= wr_data[KEY_W-1:0];
      if (hit_sby  && open_q) standby   <= wr_data[SB_W-1:0];
      if (hit_pclk && open_q) periph_en <= wr_data[PCLK_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (int'(rd_addr))
        ADR_KEY:  rd_data <= {{KEY_PAD{1'b0}}, key_q};
        ADR_SBY:  rd_data <= {{SB_PAD{1'b0}}, standby};
        ADR_PCLK: rd_data <= {{PCLK_PAD{1'b0}}, periph_en};
        default:  rd_data <= '0;
      endcase
    end
  end

  AST_KEY_ALWAYS_WRITES: assert property (@(posedge clk) disable iff (rst)
    hit_key |=> (key_q == $past(wr_data[KEY_W-1:0])));  // R2
  AST_LOCKED_SBY_STABLE: assert property (@(posedge clk) disable iff (rst)
    (hit_sby && !open_q) |=> $stable(standby));  // R3
  AST_LOCKED_PCLK_STABLE: assert property (@(posedge clk) disable iff (rst)
    (hit_pclk && !open_q) |=> $stable(periph_en));  // R3
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wfi,
  input  logic            irq,
  input  logic            nmi,
  input  logic            warmup_done,
  input  logic [SB_W-1:0] standby,
  output logic            cpu_clk_en,
  output logic            sys_clk_en,
  output logic            warmup_req
);
  lp_state_t state, nxt;
  logic      wake;

  assign wake = irq || nmi;

  always_comb begin
    nxt = state;
    unique case (state)
      LP_RUN:  if (wfi && !wake) nxt = (standby == SB_DEEP) ? LP_STOP : LP_IDLE;
      LP_IDLE: if (wake)         nxt = LP_RUN;
      LP_STOP: if (wake)         nxt = LP_WARM;
      LP_WARM: if (warmup_done)  nxt = LP_RUN;
      default:                   nxt = LP_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= LP_RUN;
      cpu_clk_en <= 1'b1;
      sys_clk_en <= 1'b1;
      warmup_req <= 1'b0;
    end else begin
      state      <= nxt;
      cpu_clk_en <= (nxt == LP_RUN);
      sys_clk_en <= (nxt == LP_RUN) || (nxt == LP_IDLE);
      warmup_req <= (nxt == LP_WARM);
    end
  end

  AST_CPU_NEEDS_SYS: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en |-> sys_clk_en);  // R6
  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state == LP_RUN && wfi && !wake && standby != SB_DEEP) |=> (!cpu_clk_en && sys_clk_en));  // R4
  AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state == LP_IDLE && wake) |=> cpu_clk_en);  // R7
  AST_STOP_WAKE: assert property (@(posedge clk) disable iff (rst)
    (state == LP_STOP && wake) |=> (warmup_req && !sys_clk_en));  // R8
  AST_WARM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == LP_WARM && !warmup_done) |=> (warmup_req && !cpu_clk_en));  // R8
  AST_PENDING_WAKE: assert property (@(posedge clk) disable iff (rst)
    (state == LP_RUN && wfi && wake) |=> cpu_clk_en);  // R9
  AST_RESET_RUN: assert property (@(posedge clk)
    $past(rst) |-> (cpu_clk_en && sys_clk_en && !warmup_req));  // R10
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int PCLK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wfi,
  input  logic              irq,
  input  logic              nmi,
  input  logic              warmup_done,
  output logic              cpu_clk_en,
  output logic              sys_clk_en,
  output logic              warmup_req,
  output logic [PCLK_W-1:0] periph_clk_en
);
  logic [SB_W-1:0] standby;

  lpm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PCLK_W(PCLK_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .standby   (standby),
    .periph_en (periph_clk_en)
  );

  lpm_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .wfi         (wfi),
    .irq         (irq),
    .nmi         (nmi),
    .warmup_done (warmup_done),
    .standby     (standby),
    .cpu_clk_en  (cpu_clk_en),
    .sys_clk_en  (sys_clk_en),
    .warmup_req  (warmup_req)
  );
endmodule

// File: tb/lpm_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_ctrl_tb;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int PCLK_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic wfi = 1'b0, irq = 1'b0, nmi = 1'b0, wdone = 1'b0;
  logic cpu_clk_en, sys_clk_en, warmup_req;
  logic [PCLK_W-1:0] periph_clk_en;

  always #4 clk = ~clk;

  lpm_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PCLK_W(PCLK_W)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wfi(wfi), .irq(irq), .nmi(nmi),
    .warmup_done(wdone), .cpu_clk_en(cpu_clk_en), .sys_clk_en(sys_clk_en),
    .warmup_req(warmup_req), .periph_clk_en(periph_clk_en)
  );

  // kind 0: {cpu,sys,warm}; kind 1: rd_data; kind 2: periph_clk_en
  typedef struct {
    int          due;
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc++;

  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        logic [31:0] obs;
        it = q.pop_front();
        case (it.kind)
          0:       obs = {29'd0, cpu_clk_en, sys_clk_en, warmup_req};
          1:       obs = rd_data;
          default: obs = {{(32-PCLK_W){1'b0}}, periph_clk_en};
        endcase
        checks++;
        if (obs !== it.exp) begin
          fails++;
          $display("FAIL %s kind=%0d actual=0x%08h expected=0x%08h", it.req, it.kind, obs, it.exp);
        end
      end
    end
  end

  task automatic push(int kind, logic [31:0] exp, string req);
    item_t it;
    it.due = cyc + 1; it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic step(bit w, bit i, bit n, bit d, logic [2:0] exp, string req);
    @(negedge clk);
    wr_en = 1'b0; wfi = w; irq = i; nmi = n; wdone = d;
    push(0, {29'd0, exp}, req);
  endtask

  task automatic wr(int addr, logic [31:0] data);
    @(negedge clk);
    wfi = 1'b0; irq = 1'b0; nmi = 1'b0; wdone = 1'b0;
    wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = data;
  endtask

  task automatic rd_chk(int addr, logic [31:0] exp, string req);
    @(negedge clk);
    wr_en = 1'b0; wfi = 1'b0; irq = 1'b0; nmi = 1'b0; wdone = 1'b0;
    rd_addr = ADDR_W'(addr);
    push(1, exp, req);
  endtask

  task automatic pe_chk(logic [31:0] exp, string req);
    @(negedge clk);
    wr_en = 1'b0; wfi = 1'b0; irq = 1'b0; nmi = 1'b0; wdone = 1'b0;
    push(2, exp, req);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    @(negedge clk); rst = 1'b1;
    push(0, 32'd6, "R1"); push(2, 32'd0, "R1");
    @(negedge clk); rst = 1'b0;
    rd_chk(0, 32'h0000_00C1, "R1 key");
    rd_chk(1, 32'h0, "R1 standby");

    // R2 key capture with upper bits zero
    wr(0, 32'hABCD_EFC1);
    rd_chk(0, 32'h0000_00C1, "R2");
    // R3 unlocked writes
    wr(1, 32'h0000_0001);
    wr(2, 32'h0000_0005);
    rd_chk(1, 32'h1, "R3 unlocked sby");
    pe_chk(32'h5, "R3 unlocked pclk");
    // R3 locked writes discarded
    wr(0, 32'h1234_5600);
    rd_chk(0, 32'h0, "R2 lock value");
    wr(1, 32'h0);
    wr(2, 32'hF);
    rd_chk(1, 32'h1, "R3 locked sby");
    pe_chk(32'h5, "R3 locked pclk");
    wr(0, 32'h0000_00C1);

    // R6 / R8 deep stop with irq exit
    step(1, 0, 0, 0, 3'b000, "R6 entry");
    step(0, 0, 0, 1, 3'b000, "R6 stay");
    pe_chk(32'h5, "R5 in stop");
    step(0, 1, 0, 0, 3'b001, "R8 wake");
    step(0, 0, 0, 0, 3'b001, "R8 hold");
    step(0, 0, 0, 0, 3'b001, "R8 hold2");
    step(0, 0, 0, 1, 3'b110, "R8 done");
    step(0, 0, 0, 0, 3'b110, "R8 run");

    // R8 nmi exit from stop
    step(1, 0, 0, 0, 3'b000, "R6 entry2");
    step(0, 0, 1, 0, 3'b001, "R8 nmi");
    step(0, 0, 0, 1, 3'b110, "R8 done2");

    // R9 pending wake cancels entry
    step(1, 1, 0, 0, 3'b110, "R9 irq");
    step(1, 0, 1, 0, 3'b110, "R9 nmi");

    // R10 reset during stop
    step(1, 0, 0, 0, 3'b000, "R10 pre");
    @(negedge clk); rst = 1'b1; wfi = 1'b0; push(0, 32'd6, "R10");
    @(negedge clk); rst = 1'b0;

    // R4 / R5 / R7 idle with each non-deep code
    wr(2, 32'h0000_005A);
    wr(1, 32'h0);
    step(1, 0, 0, 0, 3'b010, "R4 code00");
    pe_chk(32'h5A, "R5 in idle");
    step(0, 0, 0, 1, 3'b010, "R4 stay");
    step(0, 1, 0, 0, 3'b110, "R7 irq");
    wr(1, 32'h2);
    step(1, 0, 0, 0, 3'b010, "R4 code10");
    step(0, 0, 1, 0, 3'b110, "R7 nmi");
    wr(1, 32'h3);
    step(1, 0, 0, 0, 3'b010, "R4 code11");
    step(0, 1, 0, 0, 3'b110, "R7 irq2");
    step(0, 0, 0, 0, 3'b110, "R7 run");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule